// File: doc/BRIEF.md
# Split Octal Front Panel Display Driver

This block drives a nine-digit, time-multiplexed seven-segment panel and four status lamps. The panel is split into three fields of three digits each. The left field shows the upper byte of a 16-bit word and the middle field shows the lower byte. Each byte is written on its own as three octal digits, so the word is never shown as one continuous octal number. In memory mode the word is the address and the right field shows the data byte at that address, also in octal. In register mode the word is a register value and the right field shows a three-letter register name taken from a small glyph table.

Scanning is run by a three-state machine. ST_IDLE is entered at reset and moves to ST_LOAD on the next clock. In ST_LOAD all digit selects are off for one cycle, and the code for the current digit is captured from the live inputs. The machine then moves to ST_SHOW. ST_SHOW drives the one-hot select for that digit until the refresh timer expires. On that tick it advances the digit index, wrapping from 8 to 0, and returns to ST_LOAD. Each digit has a decimal-point enable and a blank mask bit. The lamps are registered copies of four status inputs.

Top module: `split_octal_panel`

## Requirements
- R1: While reset is asserted and directly after it, `dig_sel`, `seg`, `dp` and `lamp` are all zero. The first digit selected after reset is digit 0, the leftmost digit.
- R2: At most one bit of `dig_sel` is high at any time. Bit i selects digit i. Digits are visited in the order 0,1,...,8 and then back to 0.
- R3: Each digit's select stays high for `div_limit`+1 cycles and is followed by exactly one cycle with every select low. In that cycle `seg` and `dp` are zero. While a select is high, `seg` and `dp` do not change. If `div_limit` is lowered below the count already reached, the digit ends on the next cycle.
- R4: Digits 0-2 show the upper byte and digits 3-5 the lower byte of the shown word, split as bits [7:6], [5:3] and [2:0], so the first digit of each byte is never above 3. The shown word is `addr` when `reg_mode`=0 and `reg_val` when `reg_mode`=1.
- R5: When `reg_mode`=0, digits 6-8 show `data` split the same way.
- R6: When `reg_mode`=1, digits 6-8 show the name for `reg_sel`. The codes map as 0=" SP", 1=" AF", 2=" bC", 3=" dE", 4=" HL" and 5=" PC". A space has segment code 0x00. The letter codes are S=0x6D, P=0x73, A=0x77, F=0x71, b=0x7C, C=0x39, d=0x5E, E=0x79, H=0x76 and L=0x38.
- R7: In register mode, `reg_sel` codes 6 and 7 show three dashes, code 0x40 on each of digits 6-8.
- R8: `seg` is active high, with bit order {g,f,e,d,c,b,a}. The octal values 0-7 have the codes 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D and 0x07.
- R9: `dp` is high while digit i is selected if `dp_en[i]` is 1 and `blank[i]` is 0.
- R10: When `blank[i]` is 1, `seg` and `dp` are zero while digit i is selected, and the select still pulses.
- R11: A digit's contents are taken from the inputs in the ST_LOAD cycle just before its select rises. Input changes made while the digit is shown appear only on its next visit.
- R12: `lamp` equals {`power_in`,`run_in`,`monitor_in`,`irq_en_in`} (bit 3 down to bit 0), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_limit | input | DIV_W | Refresh count; each digit is shown for div_limit+1 cycles |
| reg_mode | input | 1 | 0 selects memory mode, 1 selects register mode |
| addr | input | 16 | Address word shown in memory mode |
| data | input | 8 | Data byte shown in memory mode |
| reg_val | input | 16 | Register value shown in register mode |
| reg_sel | input | 3 | Register name code |
| dp_en | input | 9 | Decimal-point enable for each digit |
| blank | input | 9 | Blank mask for each digit |
| irq_en_in | input | 1 | Interrupts-enabled status |
| monitor_in | input | 1 | Monitor-control status |
| run_in | input | 1 | Run status |
| power_in | input | 1 | Power-present status |
| dig_sel | output | 9 | One-hot digit select |
| seg | output | 7 | Segment code {g,f,e,d,c,b,a} |
| dp | output | 1 | Decimal point |
| lamp | output | 4 | Status lamps |

## Verification
Two events can fall in the same cycle. An input change can land on the ST_LOAD capture cycle, or it can land while the digit is already shown. A refresh tick can also coincide with a lowered `div_limit`. The bench rewrites the inputs every few cycles, including in the capture cycle, and changes `div_limit` in the middle of a digit. A behavioural model of the scan judges each outcome on every clock: the value captured in ST_LOAD is the one expected, and a later change is expected only on the next visit. Blank bits that overlap decimal-point enables on the same digit are judged the same way.

// File: rtl/spo_pkg.sv
package spo_pkg;
    localparam int NUM_DIGITS = 9;
    localparam int IDX_W      = $clog2(NUM_DIGITS);
    localparam int SEG_W      = 7;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHOW
    } scan_state_t;

    localparam logic [SEG_W-1:0] GL_SPACE = 7'h00;
    localparam logic [SEG_W-1:0] GL_DASH  = 7'h40;
    localparam logic [SEG_W-1:0] GL_S     = 7'h6D;
    localparam logic [SEG_W-1:0] GL_P     = 7'h73;
    localparam logic [SEG_W-1:0] GL_A     = 7'h77;
    localparam logic [SEG_W-1:0] GL_F     = 7'h71;
    localparam logic [SEG_W-1:0] GL_B     = 7'h7C;
    localparam logic [SEG_W-1:0] GL_C     = 7'h39;
    localparam logic [SEG_W-1:0] GL_D     = 7'h5E;
    localparam logic [SEG_W-1:0] GL_E     = 7'h79;
    localparam logic [SEG_W-1:0] GL_H     = 7'h76;
    localparam logic [SEG_W-1:0] GL_L     = 7'h38;

    function automatic logic [SEG_W-1:0] octal_glyph(input logic [2:0] v);
        logic [SEG_W-1:0] r;
        unique case (v)
            3'd0: r = 7'h3F;
            3'd1: r = 7'h06;
            3'd2: r = 7'h5B;
            3'd3: r = 7'h4F;
            3'd4: r = 7'h66;
            3'd5: r = 7'h6D;
            3'd6: r = 7'h7D;
            default: r = 7'h07;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] octal_part(input logic [BYTE_W-1:0] b, input int pos);
        logic [2:0] r;
        if (pos == 0)      r = {1'b0, b[7:6]};
        else if (pos == 1) r = b[5:3];
        else               r = b[2:0];
        return r;
    endfunction
endpackage

// File: rtl/spo_refresh_timer.sv
module spo_refresh_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spo_glyph_table.sv
module spo_glyph_table
    import spo_pkg::*;
#(
    parameter int POS = 0
) (
    input  logic [2:0]       reg_sel,
    output logic [SEG_W-1:0] glyph
);
    always_comb begin
        unique case (reg_sel)
            3'd0: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_S : GL_P;
            3'd1: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_A : GL_F;
            3'd2: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_B : GL_C;
            3'd3: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_D : GL_E;
            3'd4: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_H : GL_L;
            3'd5: glyph = (POS == 0) ? GL_SPACE : (POS == 1) ? GL_P : GL_C;
            default: glyph = GL_DASH;
        endcase
    end
endmodule

// File: rtl/spo_digit_source.sv
module spo_digit_source
    import spo_pkg::*;
(
    input  logic              reg_mode,
    input  logic [WORD_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    input  logic [WORD_W-1:0] reg_val,
    input  logic [2:0]        reg_sel,
    input  logic [IDX_W-1:0]  idx,
    output logic [SEG_W-1:0]  code
);
    localparam int FIELDS = NUM_DIGITS / 3;

    logic [WORD_W-1:0] word;
    logic [SEG_W-1:0]  codes [NUM_DIGITS];

    assign word = reg_mode ? reg_val : addr;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        localparam int FIELD = g / 3;
        localparam int POS   = g % 3;
        if (FIELD < FIELDS - 1) begin : g_word
            logic [BYTE_W-1:0] byte_v;
            assign byte_v   = word[(FIELDS - 2 - FIELD) * BYTE_W +: BYTE_W];
            assign codes[g] = octal_glyph(octal_part(byte_v, POS));
        end else begin : g_right
            logic [SEG_W-1:0] name_glyph;
            spo_glyph_table #(.POS(POS)) u_glyph (
                .reg_sel (reg_sel),
                .glyph   (name_glyph)
            );
            assign codes[g] = reg_mode ? name_glyph
                                       : octal_glyph(octal_part(data, POS));
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (idx == IDX_W'(i)) code = codes[i];
        end
    end
endmodule

// File: rtl/split_octal_panel.sv
module split_octal_panel
    import spo_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_limit,
    input  logic              reg_mode,
    input  logic [15:0]       addr,
    input  logic [7:0]        data,
    input  logic [15:0]       reg_val,
    input  logic [2:0]        reg_sel,
    input  logic [8:0]        dp_en,
    input  logic [8:0]        blank,
    input  logic              irq_en_in,
    input  logic              monitor_in,
    input  logic              run_in,
    input  logic              power_in,
    output logic [8:0]        dig_sel,
    output logic [6:0]        seg,
    output logic              dp,
    output logic [3:0]        lamp
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

    scan_state_t            state_q, state_d;
    logic [IDX_W-1:0]       idx_q;
    logic                   tick;
    logic [SEG_W-1:0]       code;
    logic [NUM_DIGITS-1:0]  sel_q;
    logic [SEG_W-1:0]       seg_q;
    logic                   dp_q;
    logic [3:0]             lamp_q;
    logic                   cur_blank;
    logic                   cur_dp;

    spo_refresh_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SHOW),
        .limit (div_limit),
        .tick  (tick)
    );

    spo_digit_source u_source (
        .reg_mode (reg_mode),
        .addr     (addr),
        .data     (data),
        .reg_val  (reg_val),
        .reg_sel  (reg_sel),
        .idx      (idx_q),
        .code     (code)
    );

    always_comb begin
        cur_blank = 1'b0;
        cur_dp    = 1'b0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (idx_q == IDX_W'(i)) begin
                cur_blank = blank[i];
                cur_dp    = dp_en[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_LOAD;
            ST_LOAD: state_d = ST_SHOW;
            ST_SHOW: state_d = tick ? ST_LOAD : ST_SHOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SHOW && tick) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            seg_q  <= '0;
            dp_q   <= 1'b0;
            lamp_q <= '0;
        end else begin
            lamp_q <= {power_in, run_in, monitor_in, irq_en_in};
            unique case (state_q)
                ST_LOAD: begin
                    sel_q <= NUM_DIGITS'(1) << idx_q;
                    seg_q <= cur_blank ? '0 : code;
                    dp_q  <= cur_dp & ~cur_blank;
                end
                ST_SHOW: begin
                    if (tick) begin
                        sel_q <= '0;
                        seg_q <= '0;
                        dp_q  <= 1'b0;
                    end
                end
                default: begin
                    sel_q <= '0;
                    seg_q <= '0;
                    dp_q  <= 1'b0;
                end
            endcase
        end
    end

    assign dig_sel = sel_q;
    assign seg     = seg_q;
    assign dp      = dp_q;
    assign lamp    = lamp_q;
endmodule

// File: rtl/spo_checker.sv
module spo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] dig_sel,
    input logic [6:0] seg,
    input logic       dp,
    input logic [3:0] lamp,
    input logic       irq_en_in,
    input logic       monitor_in,
    input logic       run_in,
    input logic       power_in
);
    logic [8:0] last_sel_q;
    logic [8:0] next_sel;
    logic       armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_sel_q <= '0;
            armed_q    <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (dig_sel != 9'd0) last_sel_q <= dig_sel;
        end
    end

    assign next_sel = (last_sel_q == 9'd0 || last_sel_q[8]) ? 9'd1 : (last_sel_q << 1);

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_sel));

    assert_scan_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dig_sel) |-> dig_sel == next_sel);

    assert_gap_before_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel != 9'd0) |=> (dig_sel == 9'd0 || dig_sel == $past(dig_sel)));

    assert_dark_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel == 9'd0) |-> (seg == 7'd0 && !dp));

    assert_stable_while_shown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel != 9'd0 && $past(dig_sel) == dig_sel) |-> ($stable(seg) && $stable(dp)));

    assert_lamp_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> lamp == $past({power_in, run_in, monitor_in, irq_en_in}));
endmodule

bind split_octal_panel spo_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dig_sel    (dig_sel),
    .seg        (seg),
    .dp         (dp),
    .lamp       (lamp),
    .irq_en_in  (irq_en_in),
    .monitor_in (monitor_in),
    .run_in     (run_in),
    .power_in   (power_in)
);

// File: tb/split_octal_panel_tb.sv
module split_octal_panel_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_limit = 8'd2;
    logic             reg_mode = 1'b0;
    logic [15:0]      addr = '0;
    logic [7:0]       data = '0;
    logic [15:0]      reg_val = '0;
    logic [2:0]       reg_sel = '0;
    logic [8:0]       dp_en = '0;
    logic [8:0]       blank = '0;
    logic             irq_en_in = 1'b0, monitor_in = 1'b0, run_in = 1'b0, power_in = 1'b0;
    logic [8:0]       dig_sel;
    logic [6:0]       seg;
    logic             dp;
    logic [3:0]       lamp;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    split_octal_panel #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .div_limit(div_limit), .reg_mode(reg_mode),
        .addr(addr), .data(data), .reg_val(reg_val), .reg_sel(reg_sel),
        .dp_en(dp_en), .blank(blank), .irq_en_in(irq_en_in),
        .monitor_in(monitor_in), .run_in(run_in), .power_in(power_in),
        .dig_sel(dig_sel), .seg(seg), .dp(dp), .lamp(lamp)
    );

    always #2 clk = ~clk;

    function automatic logic [6:0] oct_code(int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; default: return 7'h07;
        endcase
    endfunction

    function automatic logic [6:0] name_code(int s, int pos);
        if (s > 5) return 7'h40;
        if (pos == 0) return 7'h00;
        case (s)
            0: return (pos == 1) ? 7'h6D : 7'h73;
            1: return (pos == 1) ? 7'h77 : 7'h71;
            2: return (pos == 1) ? 7'h7C : 7'h39;
            3: return (pos == 1) ? 7'h5E : 7'h79;
            4: return (pos == 1) ? 7'h76 : 7'h38;
            default: return (pos == 1) ? 7'h73 : 7'h39;
        endcase
    endfunction

    function automatic int oct_digit(int b, int pos);
        if (pos == 0) return b / 64;
        if (pos == 1) return (b / 8) % 8;
        return b % 8;
    endfunction

    function automatic logic [6:0] ref_code(int i);
        int w, b, pos;
        w   = reg_mode ? int'(reg_val) : int'(addr);
        pos = i % 3;
        if (i < 6) begin
            b = (i < 3) ? w / 256 : w % 256;
            return oct_code(oct_digit(b, pos));
        end
        if (reg_mode) return name_code(int'(reg_sel), pos);
        return oct_code(oct_digit(int'(data), pos));
    endfunction

    // Behavioural scan model: 0 idle, 1 capture, 2 showing
    int         m_st = 0, m_idx = 0, m_cnt = 0;
    logic [8:0] e_sel = '0;
    logic [6:0] e_seg = '0;
    logic       e_dp = 1'b0;
    logic [3:0] e_lamp = '0;
    bit         e_mode = 1'b0;
    int         e_rsel = 0;
    bit         e_blank = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_cnt = 0;
            e_sel = '0; e_seg = '0; e_dp = 1'b0; e_lamp = '0;
        end else begin
            e_lamp = {power_in, run_in, monitor_in, irq_en_in};
            case (m_st)
                0: m_st = 1;
                1: begin
                    e_sel   = 9'd1 << m_idx;
                    e_blank = blank[m_idx];
                    e_mode  = reg_mode;
                    e_rsel  = int'(reg_sel);
                    e_seg   = blank[m_idx] ? 7'h00 : ref_code(m_idx);
                    e_dp    = dp_en[m_idx] & ~blank[m_idx];
                    m_cnt   = 0;
                    m_st    = 2;
                end
                default: begin
                    if (m_cnt >= int'(div_limit)) begin
                        e_sel = '0; e_seg = '0; e_dp = 1'b0;
                        m_idx = (m_idx == 8) ? 0 : m_idx + 1;
                        m_st  = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            endcase
        end
    end

    function automatic string seg_tag();
        if (e_blank && e_sel != 0) return "R10";
        if (e_sel[5:0] != 0 || e_sel == 0) return "R4 R8 R11";
        if (!e_mode) return "R5 R8 R11";
        if (e_rsel > 5) return "R7";
        return "R6";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(dig_sel == e_sel, "R2 R3", "dig_sel", int'(dig_sel), int'(e_sel));
            check(seg == e_seg, seg_tag(), "seg", int'(seg), int'(e_seg));
            check(dp == e_dp, "R9", "dp", int'(dp), int'(e_dp));
            check(lamp == e_lamp, "R12", "lamp", int'(lamp), int'(e_lamp));
        end
    end

    task automatic run_cycles(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_digit(int d);
        int guard = 0;
        while (dig_sel != (9'd1 << d) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic scramble();
        addr       = 16'($urandom);
        data       = 8'($urandom);
        reg_val    = 16'($urandom);
        reg_sel    = 3'($urandom);
        reg_mode   = 1'($urandom);
        dp_en      = 9'($urandom);
        blank      = 9'($urandom) & 9'($urandom);
        {irq_en_in, monitor_in, run_in, power_in} = 4'($urandom);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        irq_en_in = 1'b1; power_in = 1'b1;
        run_cycles(3);
        // R1: outputs dark under reset
        check(dig_sel == 0 && seg == 0 && !dp && lamp == 0, "R1", "reset outputs",
              int'({dig_sel, seg, dp, lamp}), 0);
        rst_n = 1'b1;
        run_cycles(2);
        // R1: first digit after reset is the leftmost
        check(dig_sel == 9'd1, "R1", "first select", int'(dig_sel), 1);

        // memory mode, fixed pattern (R4 R5 R8)
        addr = 16'hA5C3; data = 8'h7E;
        run_cycles(2 * 9 * 4);
        div_limit = 8'd0;
        addr = 16'hFFFF; data = 8'hC0;
        run_cycles(2 * 9 * 2);

        // register mode names, every code (R6 R7)
        div_limit = 8'd1;
        reg_mode = 1'b1; reg_val = 16'h1234;
        for (int s = 0; s < 8; s++) begin
            reg_sel = 3'(s);
            reg_val = reg_val + 16'h0F0F;
            run_cycles(9 * 3 + 3);
        end
        reg_sel = 3'd6;
        wait_digit(6);
        run_cycles(1);
        check(seg == 7'h40, "R7", "dash on unused code", int'(seg), 'h40);

        // decimal points and blanking overlapping on digits (R9 R10)
        reg_mode = 1'b0;
        dp_en = 9'b1_0101_0101; blank = 9'b0_0110_0011;
        run_cycles(2 * 9 * 3);
        wait_digit(1);
        run_cycles(1);
        check(seg == 0 && !dp, "R10", "blanked digit", int'({seg, dp}), 0);

        // R11: change while shown, must not appear until next visit
        div_limit = 8'd4; blank = '0; data = 8'h00;
        wait_digit(8);
        data = 8'hFF;
        run_cycles(1);
        check(seg == 7'h3F, "R11", "held code", int'(seg), 'h3F);

        // R3: lower limit mid-digit
        div_limit = 8'd6;
        wait_digit(2);
        run_cycles(3);
        div_limit = 8'd1;
        run_cycles(1);
        check(dig_sel == 9'd0, "R3", "early end on lowered limit", int'(dig_sel), 0);

        // heavy churn, including changes on the capture cycle
        for (int ph = 0; ph < 4; ph++) begin
            div_limit = 8'(ph);
            for (int k = 0; k < 300; k++) begin
                if (k % 3 == 0) scramble();
                @(negedge clk);
            end
        end

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule